// File: doc/BRIEF.md
# Fixed-Ratio Digital Quadrature Upconverter

This block mixes a stream of interpolated complex baseband samples with a digital quadrature carrier. The carrier runs at one half, one quarter or one eighth of the sample rate. Two real outputs are produced, one for each converter channel. One is the modulated IF signal and the other is the same signal shifted by 90 degrees. Together they feed an external analog quadrature modulator that completes an image-rejecting upconversion. A control bit flips the sign of the sine terms, and this chooses which sideband the analog stage cancels.

Because the carrier frequency is restricted to these three ratios, every carrier value is 0, ±1 or ±√2/2. A three-bit phase counter indexes one computed eight-entry cosine sequence, so no NCO is needed. The sine is read from the same sequence, two steps behind. The half-rate setting alternates the sign of each sample, which moves the spectrum so that image pairs sit at multiples of half the update rate. A bypass setting passes I and Q through unmixed. Outputs are one bit wider than the inputs and are clipped to that range.

Top module: `qmod_fsn`

## Requirements
- R1: After a synchronous active-low reset, `out_valid`, `out_a` and `out_b` are 0, and the first accepted sample after reset uses phase 0.
- R2: Mode code 0 (bypass): one cycle after an accepted sample, `out_a` equals `in_i` and `out_b` equals `in_q`, both sign-extended.
- R3: Mode code 1 (half rate): the carrier cosine is +1 on even phases and −1 on odd phases, and the sine is 0. So `out_a` = ±`in_i` and `out_b` = ±`in_q`.
- R4: Mode code 2 (quarter rate): for phase p mod 4 = 0,1,2,3 the cosine is 1,0,−1,0 and the sine is 0,1,0,−1.
- R5: Mode code 3 (eighth rate): for phase p = 0..7 the cosine is 1,h,0,−h,−1,−h,0,h and the sine is the cosine at p−2 (mod 8). Here h = 23170/32768 and 1 = 32768/32768.
- R6: With `img_sel` = 0, `out_a` = floor((I·C − Q·S)/32768) and `out_b` = floor((I·S + Q·C)/32768), where C and S are the coefficients scaled by 32768. With `img_sel` = 1, S is negated in both expressions.
- R7: The phase counter steps by one (mod 8) on each cycle with `in_valid` high, in every mode, and holds otherwise. `out_valid` is `in_valid` delayed by one cycle. On cycles without a new sample, `out_a` and `out_b` hold their previous values.
- R8: Outputs are DW+1 bits wide and are clipped to [−2^DW, 2^DW−1]. Negating a full-scale negative input (−2048 at DW=12) therefore yields +2048.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | 0 bypass, 1 half rate, 2 quarter rate, 3 eighth rate |
| img_sel | input | 1 | Negates the sine terms to pick the rejected image |
| in_valid | input | 1 | A new I/Q sample is present |
| in_i | input | DW (12) | In-phase sample, two's complement |
| in_q | input | DW (12) | Quadrature sample, two's complement |
| out_valid | output | 1 | Outputs carry a new result |
| out_a | output | DW+1 (13) | I·cos − Q·sin |
| out_b | output | DW+1 (13) | I·sin + Q·cos |

## Verification
The bench drives full-scale values, including −2048 at the quarter-rate and half-rate points where negation is needed. A design without the guard bit would wrap that result to −2048. It also drives equal I and Q at eighth rate, where `out_b` climbs to about 2894. A truncated sum would show up there, and so would a wrong √2/2 constant or an off-by-one sine index. Idle gaps between samples and mode switches in mid-stream expose a phase counter that runs freely or restarts. A mid-run reset checks that the sequence starts again at phase 0. Runs with both `img_sel` values catch a sign flip applied to the wrong term.

// File: rtl/qmod_pkg.sv
// Shared types for the fixed-ratio quadrature upconverter.
package qmod_pkg;

    // Carrier selection; the code values are part of the port contract.
    typedef enum logic [1:0] {
        MODE_BYPASS  = 2'd0,
        MODE_HALF    = 2'd1,
        MODE_QUARTER = 2'd2,
        MODE_EIGHTH  = 2'd3
    } qmod_mode_e;

endpackage

// File: rtl/qmod_carrier.sv
// Phase counter and carrier coefficient source.
// Produces cos/sin scaled by 2^(CW-1) for the current sample phase.
// Assumes one phase step per accepted sample; the sine is the cosine
// sequence read two eighth-turn steps behind.
module qmod_carrier
    import qmod_pkg::*;
#(
    parameter int CW        = 16,
    parameter int ROOT_HALF = 23170
) (
    input  logic               clk,
    input  logic               rst_n,
    input  qmod_mode_e         mode,
    input  logic               advance,
    output logic signed [CW:0] cos_o,
    output logic signed [CW:0] sin_o
);
    localparam logic signed [CW:0] K_ONE = (CW+1)'(1 << (CW-1));
    localparam logic signed [CW:0] K_RT  = (CW+1)'(ROOT_HALF);

    logic [2:0] phase_q;
    logic [2:0] idx;

    // One eighth-turn cosine value per index.
    function automatic logic signed [CW:0] cos8(input logic [2:0] k);
        case (k)
            3'd0:    cos8 = K_ONE;
            3'd1:    cos8 = K_RT;
            3'd3:    cos8 = -K_RT;
            3'd4:    cos8 = -K_ONE;
            3'd5:    cos8 = -K_RT;
            3'd7:    cos8 = K_RT;
            default: cos8 = '0;
        endcase
    endfunction

    // Step the phase on each accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n)       phase_q <= '0;
        else if (advance) phase_q <= phase_q + 3'd1;
    end

    // Scale the phase into eighth-turn steps for the chosen rate.
    always_comb begin
        case (mode)
            MODE_HALF:    idx = {phase_q[0], 2'b00};
            MODE_QUARTER: idx = {phase_q[1:0], 1'b0};
            MODE_EIGHTH:  idx = phase_q;
            default:      idx = 3'd0;
        endcase
    end

    // Look up the cosine, and the sine as the cosine two steps behind.
    always_comb begin
        cos_o = cos8(idx);
        sin_o = cos8(idx - 3'd2);
    end

    p_phase_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> phase_q == 3'($past(phase_q) + 3'd1));
    p_phase_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(phase_q));
    p_half_nosine_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mode == MODE_HALF |-> sin_o == '0);
    p_quarter_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mode == MODE_QUARTER |-> ((cos_o == '0) != (sin_o == '0)));

endmodule

// File: rtl/qmod_mixer.sv
// Complex-by-carrier multiply with floor scaling and clipping.
// a = I*C - g*Q*S, b = g*I*S + Q*C, with g = -1 when img_sel is set.
// Assumes coefficients scaled by 2^(CW-1); purely combinational.
module qmod_mixer #(
    parameter int DW = 12,
    parameter int CW = 16,
    parameter int OW = DW + 1
) (
    input  logic signed [DW-1:0] in_i,
    input  logic signed [DW-1:0] in_q,
    input  logic signed [CW:0]   cos_c,
    input  logic signed [CW:0]   sin_c,
    input  logic                 img_sel,
    output logic signed [OW-1:0] mix_a,
    output logic signed [OW-1:0] mix_b
);
    localparam int PW = DW + CW + 1;
    localparam int SW = PW + 1;
    localparam int SH = CW - 1;
    localparam logic signed [SW-1:0] HI = SW'((1 <<< (OW-1)) - 1);
    localparam logic signed [SW-1:0] LO = -SW'(1 <<< (OW-1));

    logic signed [CW:0]   sin_e;
    logic signed [PW-1:0] p_ic, p_qs, p_is, p_qc;
    logic signed [SW-1:0] sum_a, sum_b, sh_a, sh_b;

    // Clip a scaled sum to the output range.
    function automatic logic signed [OW-1:0] clip(input logic signed [SW-1:0] v);
        if (v > HI)      clip = OW'(HI);
        else if (v < LO) clip = OW'(LO);
        else             clip = OW'(v);
    endfunction

    // Apply the image choice to the sine.
    always_comb sin_e = img_sel ? -sin_c : sin_c;

    // Four products, two sums, floor scaling and clipping.
    always_comb begin
        p_ic  = PW'(in_i) * PW'(cos_c);
        p_qs  = PW'(in_q) * PW'(sin_e);
        p_is  = PW'(in_i) * PW'(sin_e);
        p_qc  = PW'(in_q) * PW'(cos_c);
        sum_a = SW'(p_ic) - SW'(p_qs);
        sum_b = SW'(p_is) + SW'(p_qc);
        sh_a  = sum_a >>> SH;
        sh_b  = sum_b >>> SH;
        mix_a = clip(sh_a);
        mix_b = clip(sh_b);
    end

endmodule

// File: rtl/qmod_fsn.sv
// Fixed-ratio digital quadrature upconverter, top level.
// Mixes I/Q with a carrier at Fs/2, Fs/4 or Fs/8 (or passes them
// through) and registers two orthogonal real outputs one cycle later.
// Assumes two's-complement inputs; the phase advances only on valid samples.
module qmod_fsn
    import qmod_pkg::*;
#(
    parameter int DW        = 12,
    parameter int CW        = 16,
    parameter int ROOT_HALF = 23170
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode,
    input  logic          img_sel,
    input  logic          in_valid,
    input  logic [DW-1:0] in_i,
    input  logic [DW-1:0] in_q,
    output logic          out_valid,
    output logic [DW:0]   out_a,
    output logic [DW:0]   out_b
);
    localparam int OW = DW + 1;

    qmod_mode_e         mode_e;
    logic signed [CW:0] cos_c, sin_c;
    logic signed [OW-1:0] mix_a, mix_b;

    // Map the raw code onto the mode type.
    always_comb mode_e = qmod_mode_e'(mode);

    qmod_carrier #(.CW(CW), .ROOT_HALF(ROOT_HALF)) u_carrier (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode_e),
        .advance (in_valid),
        .cos_o   (cos_c),
        .sin_o   (sin_c)
    );

    qmod_mixer #(.DW(DW), .CW(CW), .OW(OW)) u_mixer (
        .in_i    ($signed(in_i)),
        .in_q    ($signed(in_q)),
        .cos_c   (cos_c),
        .sin_c   (sin_c),
        .img_sel (img_sel),
        .mix_a   (mix_a),
        .mix_b   (mix_b)
    );

    // Register the valid flag every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Capture the mixed results only for accepted samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_a <= '0;
            out_b <= '0;
        end else if (in_valid) begin
            out_a <= mix_a;
            out_b <= mix_b;
        end
    end

    p_valid_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_a) && $stable(out_b)));
    p_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'd0) |=>
        (out_a == {$past(in_i[DW-1]), $past(in_i)} &&
         out_b == {$past(in_q[DW-1]), $past(in_q)}));
    p_half_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'd1) |=>
        ($signed(out_a) ==  $signed({$past(in_i[DW-1]), $past(in_i)}) ||
         $signed(out_a) == -$signed({$past(in_i[DW-1]), $past(in_i)})));

endmodule

// File: tb/qmod_fsn_bench.sv
module qmod_fsn_bench;
    localparam int DW = 12;

    typedef struct {
        int    a;
        int    b;
        string tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode = 2'd0;
    logic          img_sel = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_i = '0;
    logic [DW-1:0] in_q = '0;
    logic          out_valid;
    logic [DW:0]   out_a, out_b;

    int   n_checks = 0;
    int   n_fail = 0;
    int   ph = 0;
    int   last_a = 0;
    int   last_b = 0;
    exp_t sb[$];

    always #4 clk = ~clk;

    qmod_fsn u_qmod_fsn (
        .clk(clk), .rst_n(rst_n), .mode(mode), .img_sel(img_sel),
        .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .out_valid(out_valid), .out_a(out_a), .out_b(out_b)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Eighth-turn cosine, scaled by 32768 (R5).
    function automatic int cos8(input int k);
        case (((k % 8) + 8) % 8)
            0: return 32768;
            1: return 23170;
            3: return -23170;
            4: return -32768;
            5: return -23170;
            7: return 23170;
            default: return 0;
        endcase
    endfunction

    function automatic int clip(input int v);
        if (v > 4095)  return 4095;
        if (v < -4096) return -4096;
        return v;
    endfunction

    // Driver: present one sample and push its expected result.
    task automatic send(input int md, input bit img, input int vi, input int vq);
        int k, c, s, g;
        exp_t e;
        @(negedge clk);
        mode = md[1:0]; img_sel = img; in_valid = 1'b1;
        in_i = vi[DW-1:0]; in_q = vq[DW-1:0];
        case (md)
            1: k = (ph % 2) * 4;
            2: k = (ph % 4) * 2;
            3: k = ph % 8;
            default: k = 0;
        endcase
        c = cos8(k);
        s = cos8(k - 2);
        g = img ? -1 : 1;
        e.a = clip((vi * c - g * vq * s) >>> 15);
        e.b = clip((g * vi * s + vq * c) >>> 15);
        case (md)
            0: e.tag = "R2";
            1: e.tag = "R3";
            2: e.tag = "R4";
            default: e.tag = "R5";
        endcase
        if (img) e.tag = {e.tag, "/R6"};
        sb.push_back(e);
        ph = (ph + 1) % 8;
    endtask

    task automatic idle(input int n);
        for (int j = 0; j < n; j++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_i = 12'hA5A; in_q = 12'h5A5;
        end
    endtask

    // Monitor: pop and compare on each output, check hold otherwise.
    always @(negedge clk) begin
        if (!rst_n) begin
            last_a = 0; last_b = 0;
        end else if (out_valid) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R7 unexpected out_valid", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(int'($signed(out_a)) == e.a, {e.tag, " out_a"}, int'($signed(out_a)), e.a);
                chk(int'($signed(out_b)) == e.b, {e.tag, " out_b"}, int'($signed(out_b)), e.b);
            end
            last_a = int'($signed(out_a));
            last_b = int'($signed(out_b));
        end else begin
            chk(int'($signed(out_a)) == last_a && int'($signed(out_b)) == last_b,
                "R7 hold when idle", int'($signed(out_a)), last_a);
        end
    end

    task automatic do_reset();
        idle(3);
        @(negedge clk);
        rst_n = 1'b0;
        sb.delete();
        ph = 0;
        repeat (2) @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        chk(out_a == '0 && out_b == '0, "R1 outputs", int'($signed(out_a)), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", n_checks, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        do_reset();
        // R2 bypass, extremes
        send(0, 0, 2047, -2048);
        send(0, 1, -2048, 2047);
        send(0, 0, 5, -7);
        idle(2);
        // R3 half rate, including full-scale negation (R8)
        for (int j = 0; j < 4; j++) send(1, j % 2, -2048, 1000 - j);
        // R4 quarter rate, both images
        for (int j = 0; j < 8; j++) send(2, 0, -2048, 300 + j);
        idle(1);
        for (int j = 0; j < 8; j++) send(2, 1, 123, -2048);
        // R5 eighth rate with equal full-scale I and Q (R8 guard bit)
        for (int j = 0; j < 8; j++) send(3, 0, 2047, 2047);
        for (int j = 0; j < 8; j++) send(3, 1, -2048, 2047);
        // R7 gaps and mode changes mid-stream
        for (int j = 0; j < 40; j++) begin
            send(j % 4, j[2], int'($urandom_range(4095)) - 2048,
                 int'($urandom_range(4095)) - 2048);
            if (j % 5 == 0) idle(j % 3 + 1);
        end
        // R1 phase restart: quarter rate must start at cos=1
        do_reset();
        send(2, 0, 100, 0);
        send(2, 0, 100, 0);
        send(2, 0, 100, 0);
        idle(4);
        chk(sb.size() == 0, "R7 all results delivered", sb.size(), 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule